// File: doc/BRIEF.md
# WRED ECN Marking Engine

This block sits on the egress side of a single priority queue and makes one decision per packet: forward it untouched, rewrite its two-bit ECN field to Congestion Experienced (`11`), or flag it for dropping. The decision depends on the queue occupancy, given in packets, that is presented with the packet. That occupancy is compared against three thresholds: a low mark, a high mark and a drop limit. Between the low and high marks the engine marks packets at random. The chance of marking grows in a straight line with the occupancy. A 16-bit linear feedback shift register supplies the random values. Above the high mark every packet that can carry a mark is marked. Above the drop limit every packet is dropped.

Only the ToS byte and the IPv4 header checksum pass through the engine. When the engine sets the ECN bits it patches the checksum incrementally, so the header stays valid without summing it again. Packets enter on a valid/ready handshake. A three-state machine moves each packet through capture, decision and presentation. It has the states `ST_IDLE`, `ST_DECIDE` and `ST_EMIT`, with these transitions:
- `ST_IDLE`→`ST_DECIDE` on an accepted input.
- `ST_DECIDE`→`ST_EMIT` unconditionally.
- `ST_EMIT`→`ST_IDLE` when the consumer takes the result.
- `ST_EMIT`→`ST_EMIT` while the consumer stalls.

A registered flag reports a threshold set that is out of order.

Top module: `wred_ecn_marker`

## Requirements
- R1: When the occupancy `d` satisfies `d <= cfg_min`, the packet is forwarded with `out_tos` equal to `in_tos`, `out_csum` equal to `in_csum` and `out_drop` = 0.
- R2: When `cfg_min < d <= cfg_max`, an ECN-capable packet (ECN = `in_tos[1:0]` equal to `01` or `10`) is marked if `rnd*(cfg_max-cfg_min) < cfg_pmax*(d-cfg_min)`, where `rnd` is the random value of R8. Otherwise it is forwarded unchanged. A mark sets `out_tos[1:0]` = `11` and keeps `out_tos[7:2]`.
- R3: When `cfg_max < d <= cfg_drop`, every ECN-capable packet is marked as described in R2.
- R4: When `d > cfg_drop`, `out_drop` = 1 whatever the ECN value.
- R5: A packet with ECN `00` is never marked. Where R2 or R3 would mark it, it gets `out_drop` = 1 instead. Otherwise it is forwarded unchanged.
- R6: A packet with ECN `11` and `d <= cfg_drop` is forwarded unchanged.
- R7: When a packet is marked, `out_csum` is the incremental update of `in_csum`, so that the ones'-complement sum of the modified IPv4 header is `FFFF`. When the packet is not modified, `out_csum` equals `in_csum`.
- R8: `rnd` comes from a 16-bit Fibonacci LFSR. The next value is `{v[14:0], v[15]^v[13]^v[12]^v[10]}`. It resets to `SEED` (default `ACE1`) and steps once per accepted packet. Each packet uses the value held before its own step.
- R9: `cfg_err` rises one clock after the thresholds violate `cfg_min <= cfg_max <= cfg_drop`. It falls one clock after they satisfy it again.
- R10: `in_ready` is high only in `ST_IDLE`. `out_valid` rises two clocks after an accepting edge. While `out_valid` is high and `out_ready` is low, `out_tos`, `out_csum` and `out_drop` hold steady.
- R11: After reset, `in_ready` = 1, `out_valid` = 0 and `cfg_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min | input | DEPTH_W | Low mark: marking starts above it |
| cfg_max | input | DEPTH_W | High mark: all capable packets marked above it |
| cfg_drop | input | DEPTH_W | Drop limit: all packets dropped above it |
| cfg_pmax | input | 16 | Marking probability at the high mark, scaled by 65536 |
| cfg_err | output | 1 | Threshold ordering violated |
| in_valid | input | 1 | Packet descriptor valid |
| in_ready | output | 1 | Engine can take a packet |
| in_depth | input | DEPTH_W | Queue occupancy in packets |
| in_tos | input | 8 | Incoming ToS byte |
| in_csum | input | 16 | Incoming IPv4 header checksum |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_tos | output | 8 | Outgoing ToS byte |
| out_csum | output | 16 | Outgoing IPv4 header checksum |
| out_drop | output | 1 | Packet is to be discarded |

## Verification
Directed packets sit exactly on each threshold and one step above it, so that off-by-one errors in the region comparisons show up. At each boundary the packet is sent with each ECN codepoint, which separates the capable, incapable and already-marked rules. Random packets spread occupancy across all four regions with random threshold sets and probabilities. A bench model of the shift register then predicts each probabilistic outcome exactly, so that a wrong slope, a wrong random value or a wrong step point all give mismatched marks. Every modified header is re-summed in full, and a stall pattern on the output side confirms that held results do not move.

// File: rtl/wred_pkg.sv
package wred_pkg;

    // Occupancy region the current packet falls into
    typedef enum logic [1:0] {
        RG_PASS = 2'd0,
        RG_PROB = 2'd1,
        RG_FULL = 2'd2,
        RG_DROP = 2'd3
    } region_e;

    // Per-packet verdict
    typedef enum logic [1:0] {
        ACT_FWD  = 2'd0,
        ACT_MARK = 2'd1,
        ACT_DROP = 2'd2
    } action_e;

    // Packet flow control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_EMIT   = 2'd2
    } state_e;

    localparam logic [1:0] ECN_NONE = 2'b00;
    localparam logic [1:0] ECN_CE   = 2'b11;

    // Ones'-complement 16-bit addition with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

endpackage

// File: rtl/wred_lfsr.sv
module wred_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] value
);

    logic feedback;

    always_comb begin
        feedback = value[15] ^ value[13] ^ value[12] ^ value[10];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else if (step) begin
            value <= {value[14:0], feedback};
        end
    end

    // R8: a maximal-length register never reaches the all-zero lockup state
    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        value != 16'd0);

    // R8: every step produces a different value
    p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> value != $past(value));

endmodule

// File: rtl/wred_region.sv
module wred_region #(
    parameter int DW = 12,
    parameter int PW = 16
) (
    input  logic [DW-1:0]     depth,
    input  logic [DW-1:0]     thr_min,
    input  logic [DW-1:0]     thr_max,
    input  logic [DW-1:0]     thr_drop,
    input  logic [PW-1:0]     pmax,
    input  logic [PW-1:0]     rnd,
    output wred_pkg::region_e region,
    output logic              prob_hit
);
    import wred_pkg::*;

    localparam int PRODW = DW + PW;

    logic [DW-1:0]    span;
    logic [DW-1:0]    excess;
    logic [PRODW-1:0] lhs;
    logic [PRODW-1:0] rhs;

    // Region by strict "exceeds" comparisons, highest limit first
    always_comb begin
        if (depth > thr_drop) begin
            region = RG_DROP;
        end else if (depth > thr_max) begin
            region = RG_FULL;
        end else if (depth > thr_min) begin
            region = RG_PROB;
        end else begin
            region = RG_PASS;
        end
    end

    // Linear ramp without a divider: rnd/2^16 < pmax/2^16 * excess/span
    always_comb begin
        span     = thr_max - thr_min;
        excess   = depth - thr_min;
        lhs      = PRODW'(rnd) * PRODW'(span);
        rhs      = PRODW'(pmax) * PRODW'(excess);
        prob_hit = (region == RG_PROB) && (lhs < rhs);
    end

endmodule

// File: rtl/wred_csum_patch.sv
module wred_csum_patch (
    input  logic [15:0] csum_in,
    input  logic [7:0]  old_byte,
    input  logic [7:0]  new_byte,
    output logic [15:0] csum_out
);
    import wred_pkg::*;

    logic [15:0] partial;
    logic [15:0] total;

    // HC' = ~(~HC + ~m + m'); the upper byte of the word cancels out
    always_comb begin
        partial  = oc_add(~csum_in, ~{8'h00, old_byte});
        total    = oc_add(partial, {8'h00, new_byte});
        csum_out = ~total;
    end

endmodule

// File: rtl/wred_ecn_marker.sv
module wred_ecn_marker #(
    parameter int          DEPTH_W = 12,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] cfg_min,
    input  logic [DEPTH_W-1:0] cfg_max,
    input  logic [DEPTH_W-1:0] cfg_drop,
    input  logic [15:0]        cfg_pmax,
    output logic               cfg_err,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DEPTH_W-1:0] in_depth,
    input  logic [7:0]         in_tos,
    input  logic [15:0]        in_csum,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_tos,
    output logic [15:0]        out_csum,
    output logic               out_drop
);
    import wred_pkg::*;

    localparam int RND_W = 16;

    state_e             state;
    state_e             state_nx;
    logic               accept;

    logic [DEPTH_W-1:0] depth_q;
    logic [7:0]         tos_q;
    logic [15:0]        csum_q;
    logic [RND_W-1:0]   rnd_q;
    logic [RND_W-1:0]   rnd_now;

    region_e            region;
    logic               prob_hit;
    logic               want_mark;
    action_e            action;
    logic [7:0]         tos_new;
    logic [15:0]        csum_patched;

    logic [7:0]         tos_r;
    logic [15:0]        csum_r;
    logic               drop_r;
    logic               err_r;

    // ---------------- random source ----------------
    wred_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .value (rnd_now)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = ST_EMIT;
            ST_EMIT:   if (out_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_EMIT);
    assign accept    = in_valid && in_ready;

    // ---------------- capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            tos_q   <= '0;
            csum_q  <= '0;
            rnd_q   <= '0;
        end else if (accept) begin
            depth_q <= in_depth;
            tos_q   <= in_tos;
            csum_q  <= in_csum;
            rnd_q   <= rnd_now;
        end
    end

    // ---------------- decision ----------------
    wred_region #(.DW(DEPTH_W), .PW(RND_W)) u_region (
        .depth    (depth_q),
        .thr_min  (cfg_min),
        .thr_max  (cfg_max),
        .thr_drop (cfg_drop),
        .pmax     (cfg_pmax),
        .rnd      (rnd_q),
        .region   (region),
        .prob_hit (prob_hit)
    );

    always_comb begin
        want_mark = 1'b0;
        unique case (region)
            RG_PASS: want_mark = 1'b0;
            RG_PROB: want_mark = prob_hit;
            RG_FULL: want_mark = 1'b1;
            RG_DROP: want_mark = 1'b0;
            default: want_mark = 1'b0;
        endcase

        if (region == RG_DROP) begin
            action = ACT_DROP;
        end else if (tos_q[1:0] == ECN_CE) begin
            action = ACT_FWD;
        end else if (want_mark) begin
            action = (tos_q[1:0] == ECN_NONE) ? ACT_DROP : ACT_MARK;
        end else begin
            action = ACT_FWD;
        end

        tos_new = (action == ACT_MARK) ? {tos_q[7:2], ECN_CE} : tos_q;
    end

    wred_csum_patch u_csum (
        .csum_in  (csum_q),
        .old_byte (tos_q),
        .new_byte (tos_new),
        .csum_out (csum_patched)
    );

    // ---------------- output registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_r  <= '0;
            csum_r <= '0;
            drop_r <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            err_r <= !((cfg_min <= cfg_max) && (cfg_max <= cfg_drop));
            if (state == ST_DECIDE) begin
                tos_r  <= tos_new;
                csum_r <= (action == ACT_MARK) ? csum_patched : csum_q;
                drop_r <= (action == ACT_DROP);
            end
        end
    end

    assign out_tos  = tos_r;
    assign out_csum = csum_r;
    assign out_drop = drop_r;
    assign cfg_err  = err_r;

    // ---------------- assertions ----------------
    // R10: a stalled result does not move
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tos)
                                   && $stable(out_csum) && $stable(out_drop));

    // R10: no new packet is taken while a result is pending
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10: fixed two-cycle latency from acceptance to result
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid);

    // R2, R3: a forwarded packet keeps its upper six ToS bits
    p_upper_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_drop |-> out_tos[7:2] == tos_q[7:2]);

    // R5: a non-capable packet never leaves with a mark
    p_no_mark_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && tos_q[1:0] == ECN_NONE |-> out_tos[1:0] == ECN_NONE);

    // R6: an existing congestion mark is never cleared
    p_ce_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && tos_q[1:0] == ECN_CE |-> out_drop || out_tos[1:0] == ECN_CE);

    // R7: an untouched byte leaves the checksum untouched
    p_csum_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tos == tos_q |-> out_csum == csum_q);

endmodule

// File: tb/sim_wred_ecn_marker.sv
module sim_wred_ecn_marker;

    localparam int          DW   = 12;
    localparam logic [15:0] SEED = 16'hACE1;

    logic          clk;
    logic          rst_n;
    logic [DW-1:0] cfg_min, cfg_max, cfg_drop;
    logic [15:0]   cfg_pmax;
    logic          cfg_err;
    logic          in_valid, in_ready;
    logic [DW-1:0] in_depth;
    logic [7:0]    in_tos;
    logic [15:0]   in_csum;
    logic          out_valid, out_ready;
    logic [7:0]    out_tos;
    logic [15:0]   out_csum;
    logic          out_drop;

    int            n_checks = 0;
    int            n_fail   = 0;
    logic [15:0]   rnd_m;
    int            mn, mx, dr;
    logic [15:0]   pm;

    wred_ecn_marker #(.DEPTH_W(DW), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_min(cfg_min), .cfg_max(cfg_max), .cfg_drop(cfg_drop), .cfg_pmax(cfg_pmax),
        .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_depth(in_depth),
        .in_tos(in_tos), .in_csum(in_csum),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_tos(out_tos), .out_csum(out_csum), .out_drop(out_drop)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ocadd(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // 0 forward, 1 mark, 2 drop
    function automatic int model(input int d, input int lo, input int hi, input int lim,
                                 input logic [15:0] p, input logic [7:0] tos,
                                 input logic [15:0] r, output string tag);
        bit mark;
        if (d > lim) begin
            tag = "R4";
            return 2;
        end
        if (tos[1:0] == 2'b11) begin
            tag = "R6";
            return 0;
        end
        if (d > hi) begin
            mark = 1'b1;
            tag  = "R3";
        end else if (d > lo) begin
            mark = (longint'(r) * longint'(hi - lo)) < (longint'(p) * longint'(d - lo));
            tag  = "R2 R8";
        end else begin
            mark = 1'b0;
            tag  = "R1";
        end
        if (tos[1:0] == 2'b00) begin
            if (mark) tag = "R5";
            return mark ? 2 : 0;
        end
        return mark ? 1 : 0;
    endfunction

    task automatic set_cfg(input int lo, input int hi, input int lim, input logic [15:0] p);
        @(negedge clk);
        mn = lo; mx = hi; dr = lim; pm = p;
        cfg_min  = DW'(lo);
        cfg_max  = DW'(hi);
        cfg_drop = DW'(lim);
        cfg_pmax = p;
    endtask

    task automatic send(input int d, input logic [7:0] tos, input int hold);
        logic [15:0] w [10];
        logic [15:0] s, cin, s_cs;
        logic [7:0]  etos, s_tos;
        logic        s_dr;
        int          act;
        string       tag;
        w[0] = {8'h45, tos};
        for (int i = 1; i < 10; i++) w[i] = 16'($urandom);
        w[5] = 16'h0000;
        s = 16'h0000;
        for (int i = 0; i < 10; i++) s = ocadd(s, w[i]);
        cin  = ~s;
        act  = model(d, mn, mx, dr, pm, tos, rnd_m, tag);
        rnd_m = lfsr_next(rnd_m);

        @(negedge clk);
        chk(in_ready == 1'b1, "R10", "in_ready when idle", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_depth = DW'(d);
        in_tos   = tos;
        in_csum  = cin;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!out_valid && !in_ready, "R10", "busy one cycle after accept",
            32'({out_valid, in_ready}), 32'd0);
        if (hold > 0) out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R10", "out_valid two cycles after accept", 32'(out_valid), 32'd1);
        chk(out_drop == (act == 2), tag, "drop flag", 32'(out_drop), 32'(act == 2));
        if (act != 2) begin
            etos = (act == 1) ? {tos[7:2], 2'b11} : tos;
            chk(out_tos == etos, tag, "tos byte", 32'(out_tos), 32'(etos));
            if (act == 0) begin
                chk(out_csum == cin, "R7", "checksum untouched", 32'(out_csum), 32'(cin));
            end else begin
                w[0] = {8'h45, out_tos};
                w[5] = out_csum;
                s = 16'h0000;
                for (int i = 0; i < 10; i++) s = ocadd(s, w[i]);
                chk(s == 16'hFFFF, "R7", "patched header sum", 32'(s), 32'hFFFF);
            end
        end
        if (hold > 0) begin
            s_tos = out_tos; s_cs = out_csum; s_dr = out_drop;
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk(out_valid && !in_ready && out_tos == s_tos && out_csum == s_cs
                    && out_drop == s_dr, "R10", "held while stalled",
                    32'({out_valid, in_ready}), 32'h2);
            end
            out_ready = 1'b1;
            @(negedge clk);
            chk(!out_valid, "R10", "released after take", 32'(out_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20250413);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_depth = '0; in_tos = '0; in_csum = '0;
        mn = 100; mx = 200; dr = 300; pm = 16'h8000;
        cfg_min = DW'(mn); cfg_max = DW'(mx); cfg_drop = DW'(dr); cfg_pmax = pm;
        rnd_m = SEED;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
        chk(cfg_err == 1'b0, "R11", "cfg_err after reset", 32'(cfg_err), 32'd0);

        // Directed boundaries
        send(100, 8'h62, 0);  // R1 at low mark
        send(0,   8'h01, 0);  // R1 empty queue
        send(101, 8'h61, 0);  // R2 just above low mark
        send(200, 8'h62, 0);  // R2 at high mark
        send(201, 8'h62, 0);  // R3 just above high mark
        send(300, 8'h01, 0);  // R3 at drop limit
        send(301, 8'h62, 0);  // R4 above drop limit
        send(301, 8'h03, 0);  // R4 even for CE
        send(250, 8'h60, 0);  // R5 not capable in full region
        send(250, 8'h63, 0);  // R6 CE in full region
        send(50,  8'h63, 0);  // R6 CE below low mark
        send(250, 8'h62, 3);  // R10 stall on a marked result
        set_cfg(100, 200, 300, 16'h0000);
        send(199, 8'h62, 0);  // R2 zero probability never marks
        set_cfg(100, 200, 300, 16'hFFFF);
        for (int i = 0; i < 6; i++) send(190, 8'h02, 0); // R2 near-certain
        set_cfg(150, 150, 150, 16'h4000);
        send(150, 8'h01, 0);  // R1 collapsed thresholds
        send(151, 8'h01, 0);  // R4 collapsed thresholds

        // R9: ordering violations
        set_cfg(300, 200, 400, 16'h1000);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R9", "min above max", 32'(cfg_err), 32'd1);
        set_cfg(100, 500, 400, 16'h1000);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R9", "max above drop", 32'(cfg_err), 32'd1);
        set_cfg(100, 200, 400, 16'h1000);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R9", "ordered thresholds", 32'(cfg_err), 32'd0);

        // Constrained random
        for (int n = 0; n < 60; n++) begin
            int lo, hi, lim;
            lo  = $urandom_range(0, 1000);
            hi  = lo + $urandom_range(0, 800);
            lim = hi + $urandom_range(0, 800);
            set_cfg(lo, hi, lim, 16'($urandom));
            for (int j = 0; j < 8; j++) begin
                int d;
                d = $urandom_range(0, lim + 300);
                if (d > 4095) d = 4095;
                send(d, 8'($urandom), ($urandom_range(0, 7) == 0) ? 2 : 0);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule